// File: doc/BRIEF.md
# Audio Sample Error Concealment and Mute

This block cleans a stereo stream of 20-bit PCM samples arriving at the base sample rate. Each sample comes in with a tag that says which channel it belongs to, and with a flag from the upstream decoder marking it as unreliable. Left and right samples are handled alternately. Each channel keeps its own nine-sample look-ahead line. A flagged sample is rebuilt by straight-line interpolation between the last good sample and the next good sample on that channel. A gap too long to bridge is first held at the last good value and then silenced.

After concealment, a control register can apply a fixed 12 dB cut or force the output to zero. A new control value only affects samples accepted after the write. Each channel also drives an active-low silence indicator. It goes low after a long unbroken run of exactly-zero output samples on that channel.

The block sits between a serial input deserializer and an oversampling filter chain. Every input sample yields one output sample, nine samples later on the same channel, registered one clock after the input strobe.

Top module: `pcm_conceal_mute`

## Requirements
- R1: While and after synchronous reset, out_valid is 0, out_data is 0 and silent_n is 2'b11. Every delay-line slot and the last-good value reset to zero and are treated as good samples.
- R2: A strobe on in_valid produces out_valid high on the next clock, with out_chan equal to the in_chan of that strobe. If no flagged sample is involved, out_data equals the sample that came in nine strobes earlier on the same channel.
- R3: The two channels (in_chan 0 and 1) are fully independent. A sample or flag on one channel never changes the values output on the other.
- R4: A run of n flagged samples (1 <= n <= 8) that sits between a good sample A and the next good sample B is replaced as follows. The k-th sample of the run (k = 1..n) becomes A + ((B - A) * k) / (n + 1), with signed division that truncates toward zero.
- R5: In a run of 9 or more flagged samples, the first 8 output samples of the run equal the last good sample before the run, and the following samples are zero. This continues until a good sample comes out.
- R6: When the mute control bit is set, every output sample is zero.
- R7: When the attenuation bit is set and mute is clear, every output sample is the concealed sample shifted right arithmetically by 2, rounding toward minus infinity.
- R8: Mute takes priority over attenuation.
- R9: A pulse on cfg_wr loads cfg_mute and cfg_atten into the control register. A strobe in the same cycle as the write still uses the previous control value, and every later strobe uses the new one.
- R10: silent_n[c] is low exactly when the most recent 8192 output samples on channel c were all zero, and high otherwise. A non-zero output sample on c raises it on the same clock that sample appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe: a sample is present |
| in_chan | input | 1 | Channel tag of the sample, 0 left, 1 right |
| in_data | input | 20 | Signed PCM sample |
| in_err | input | 1 | High marks the sample as unreliable |
| cfg_wr | input | 1 | Load the control register |
| cfg_mute | input | 1 | Mute bit written on cfg_wr |
| cfg_atten | input | 1 | 12 dB cut bit written on cfg_wr |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Channel tag of the output sample |
| out_data | output | 20 | Concealed, level-adjusted signed sample |
| silent_n | output | 2 | Per-channel silence indication, active low |

## Verification
A wrong run counter or last-good value inside the concealer shows up as a wrong out_data on the first flagged sample that reaches the end of the line. That is nine strobes after the flag enters on that channel. A wrong long-run decision makes the whole gap follow the wrong rule: interpolation where the output should hold and then mute, or the reverse. A slip in the silence counter moves the falling edge of silent_n by at least one sample on that channel. For these reasons, a reference model tracks every channel's history and expected control state, and out_valid, out_chan, out_data and silent_n are compared against it on every clock.

// File: rtl/ecm_pkg.sv
package ecm_pkg;

    localparam int SAMPLE_W = 20;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t data;
        logic    err;
    } slot_t;

    typedef struct packed {
        logic mute;
        logic atten;
    } ctrl_t;

    // straight line from a toward b, step k of den
    function automatic sample_t lerp(sample_t a, sample_t b, int k, int den);
        int diff;
        diff = int'(b) - int'(a);
        return sample_t'(int'(a) + (diff * k) / den);
    endfunction

    function automatic sample_t apply_level(sample_t s, ctrl_t c);
        if (c.mute)
            return '0;
        else if (c.atten)
            return s >>> 2;
        else
            return s;
    endfunction

endpackage

// File: rtl/ecm_conceal.sv
module ecm_conceal
    import ecm_pkg::*;
#(
    parameter int MAX_RUN = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    shift,
    input  slot_t   din,
    output sample_t cur
);
    localparam int DEPTH = MAX_RUN + 1;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int RC_W  = $clog2(DEPTH) + 1;
    localparam logic [RC_W-1:0] RUN_LIM = RC_W'(MAX_RUN);

    slot_t            line [DEPTH];
    sample_t          last_good;
    logic [RC_W-1:0]  run_cnt;
    logic             long_run;
    logic             found;
    logic [IDX_W-1:0] g_idx;
    slot_t            oldest;
    logic             hold_mode;

    assign oldest = line[DEPTH-1];

    // nearest good sample behind the oldest slot
    always_comb begin
        found = 1'b0;
        g_idx = '0;
        for (int i = 0; i < MAX_RUN; i++) begin
            if (!line[i].err) begin
                found = 1'b1;
                g_idx = IDX_W'(i);
            end
        end
    end

    assign hold_mode = (run_cnt == '0) ? !found : long_run;

    always_comb begin
        if (!oldest.err)
            cur = oldest.data;
        else if (hold_mode)
            cur = (run_cnt < RUN_LIM) ? last_good : '0;
        else
            cur = lerp(last_good, line[g_idx].data, int'(run_cnt) + 1,
                       int'(run_cnt) + DEPTH - int'(g_idx));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) line[i] <= '0;
            last_good <= '0;
            run_cnt   <= '0;
            long_run  <= 1'b0;
        end else if (shift) begin
            line[0] <= din;
            for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
            if (oldest.err) begin
                if (run_cnt != '1) run_cnt <= run_cnt + 1'b1;
                if (run_cnt == '0) long_run <= !found;
            end else begin
                run_cnt   <= '0;
                long_run  <= 1'b0;
                last_good <= oldest.data;
            end
        end
    end

    // an interpolating run always has its closing good sample in the line
    assert_interp_target_R4: assert property (@(posedge clk) disable iff (rst)
        (oldest.err && run_cnt != '0 && !long_run) |-> found);

    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        (oldest.err && !long_run) |-> (run_cnt < RUN_LIM));

endmodule

// File: rtl/ecm_silence.sv
module ecm_silence #(
    parameter int SIL_COUNT = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic is_zero,
    output logic silent_n
);
    localparam int CW = $clog2(SIL_COUNT + 1);
    localparam logic [CW-1:0] LIM = CW'(SIL_COUNT);

    logic [CW-1:0] zcnt;

    always_ff @(posedge clk) begin
        if (rst)
            zcnt <= '0;
        else if (upd) begin
            if (!is_zero)
                zcnt <= '0;
            else if (zcnt != LIM)
                zcnt <= zcnt + 1'b1;
        end
    end

    assign silent_n = (zcnt != LIM);

    assert_break_silence_R10: assert property (@(posedge clk) disable iff (rst)
        (upd && !is_zero) |=> silent_n);

    assert_steady_R10: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(silent_n));

endmodule

// File: rtl/pcm_conceal_mute.sv
module pcm_conceal_mute
    import ecm_pkg::*;
#(
    parameter int MAX_RUN   = 8,
    parameter int SIL_COUNT = 8192
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_chan,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  logic                       in_err,
    input  logic                       cfg_wr,
    input  logic                       cfg_mute,
    input  logic                       cfg_atten,
    output logic                       out_valid,
    output logic                       out_chan,
    output logic signed [SAMPLE_W-1:0] out_data,
    output logic [1:0]                 silent_n
);
    localparam int NCH = 2;

    ctrl_t   ctrl;
    sample_t cur [NCH];
    sample_t lvl;
    slot_t   din;

    assign din = '{data: in_data, err: in_err};
    assign lvl = apply_level(cur[in_chan], ctrl);

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            logic hit;
            assign hit = in_valid && (in_chan == 1'(ch));

            ecm_conceal #(.MAX_RUN(MAX_RUN)) u_conceal (
                .clk   (clk),
                .rst   (rst),
                .shift (hit),
                .din   (din),
                .cur   (cur[ch])
            );

            ecm_silence #(.SIL_COUNT(SIL_COUNT)) u_silence (
                .clk      (clk),
                .rst      (rst),
                .upd      (hit),
                .is_zero  (lvl == '0),
                .silent_n (silent_n[ch])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            out_valid <= 1'b0;
            out_chan  <= 1'b0;
            out_data  <= '0;
        end else begin
            if (cfg_wr) ctrl <= '{mute: cfg_mute, atten: cfg_atten};
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan <= in_chan;
                out_data <= lvl;
            end
        end
    end

    assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_chan == $past(in_chan)));

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_mute_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl.mute) |=> (out_data == '0));

    assert_atten_range_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl.atten && !ctrl.mute) |=>
        ($countones(out_data[SAMPLE_W-1:SAMPLE_W-3]) == 0 ||
         $countones(out_data[SAMPLE_W-1:SAMPLE_W-3]) == 3));

endmodule

// File: tb/pcm_conceal_mute_test.sv
module pcm_conceal_mute_test;
    localparam int CLK_PERIOD = 10;
    localparam int SIL        = 8192;
    localparam int WD_LIMIT   = 150000;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_chan, in_err, cfg_wr, cfg_mute, cfg_atten;
    logic signed [19:0] in_data;
    logic out_valid, out_chan;
    logic signed [19:0] out_data;
    logic [1:0] silent_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    int hd [2][$];
    bit he [2][$];
    int sc [2];
    bit mm, ma;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_conceal_mute uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_data(in_data), .in_err(in_err), .cfg_wr(cfg_wr),
        .cfg_mute(cfg_mute), .cfg_atten(cfg_atten), .out_valid(out_valid),
        .out_chan(out_chan), .out_data(out_data), .silent_n(silent_n)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // concealed value of the sample leaving the nine-deep line on channel c
    function automatic int model_out(int c);
        int sz, p, s, q, a;
        sz = hd[c].size();
        p  = sz - 9;
        if (!he[c][p]) return hd[c][p];
        s = p;
        while (s > 0 && he[c][s-1]) s--;
        a = hd[c][s-1];
        q = -1;
        for (int i = p + 1; i < sz; i++)
            if (!he[c][i]) begin q = i; break; end
        if (q >= 0 && q - s <= 8)
            return a + ((hd[c][q] - a) * (p - s + 1)) / (q - s + 1);
        return (p - s + 1 <= 8) ? a : 0;
    endfunction

    task automatic step(bit v, bit c, int d, bit e, bit w, bit m, bit a, string tag);
        int ev;
        bit [1:0] exp_sil;
        in_valid = v; in_chan = c; in_data = d[19:0]; in_err = e;
        cfg_wr = w; cfg_mute = m; cfg_atten = a;
        ev = 0;
        if (v) begin
            ev = model_out(c);
            ev = mm ? 0 : (ma ? (ev >>> 2) : ev);
            hd[c].push_back(d);
            he[c].push_back(e);
            if (ev == 0) begin
                if (sc[c] < SIL) sc[c]++;
            end else sc[c] = 0;
        end
        if (w) begin mm = m; ma = a; end
        @(posedge clk);
        @(negedge clk);
        chk(out_valid === v, {tag, " R2 out_valid"}, int'(out_valid), int'(v));
        if (v) begin
            chk(out_chan === c, {tag, " R2 out_chan"}, int'(out_chan), int'(c));
            chk(int'(out_data) == ev, {tag, " data"}, int'(out_data), ev);
        end
        exp_sil = {sc[1] != SIL, sc[0] != SIL};
        chk(silent_n === exp_sil, "R10 silent_n", int'(silent_n), int'(exp_sil));
    endtask

    task automatic send(bit c, int d, bit e, string tag);
        step(1, c, d, e, 0, 0, 0, tag);
        step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic pair(int dl, bit el, int dr, bit er, string tag);
        send(0, dl, el, tag);
        send(1, dr, er, tag);
    endtask

    task automatic write_cfg(bit m, bit a, string tag);
        step(0, 0, 0, 0, 1, m, a, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT && !done) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 9; i++) begin hd[c].push_back(0); he[c].push_back(0); end
            sc[c] = 0;
        end
        mm = 0; ma = 0;
        rst = 1; in_valid = 0; in_chan = 0; in_data = '0; in_err = 0;
        cfg_wr = 0; cfg_mute = 0; cfg_atten = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(out_data === '0, "R1 reset out_data", int'(out_data), 0);
        chk(silent_n === 2'b11, "R1 reset silent_n", int'(silent_n), 3);
        rst = 0;

        // R2 R3: clean ramps, opposite signs per channel
        for (int i = 1; i <= 14; i++) pair(i * 1000, 0, -i * 777, 0, "R2 R3 clean");

        // R4: runs of 1, 3 and 8 on the left while the right stays clean (R3)
        pair(5000, 0, 11, 0, "R4");
        pair(99999, 1, 12, 0, "R4 run1");
        pair(-7000, 0, 13, 0, "R4");
        for (int i = 0; i < 3; i++) pair(123456, 1, 14 + i, 0, "R4 run3");
        pair(20000, 0, 17, 0, "R4");
        for (int i = 0; i < 8; i++) pair(-300000, 1, 20 + i, 0, "R4 run8");
        pair(-100001, 0, 30, 0, "R4");
        for (int i = 0; i < 3; i++) pair(40 + i, 0, -5 * i, 0, "R4 flush");
        // R4 on the right with a falling slope
        pair(1, 0, 250000, 0, "R3 R4");
        for (int i = 0; i < 5; i++) pair(2 + i, 0, 77, 1, "R3 R4 run5");
        pair(8, 0, -250001, 0, "R3 R4");

        // R5: run of 12 flagged samples on the left
        pair(31415, 0, 9, 0, "R5");
        for (int i = 0; i < 12; i++) pair(i * 3 + 1, 1, 100 + i, 0, "R5 long");
        for (int i = 0; i < 12; i++) pair(-2000 - i, 0, 200 + i, 0, "R5 recover");

        // R7: attenuation with odd negatives
        write_cfg(0, 1, "R9");
        for (int i = 0; i < 12; i++) pair(-12345 - i, 0, 54321 + i * 3, 0, "R7 atten");
        // R8: mute wins over attenuation
        write_cfg(1, 1, "R9");
        for (int i = 0; i < 10; i++) pair(6000 + i, 0, -6000 - i, 0, "R8 mute+atten");
        // R6: plain mute
        write_cfg(1, 0, "R9");
        for (int i = 0; i < 10; i++) pair(7000 + i, 0, -7000 - i, 0, "R6 mute");
        // R9: write in the same cycle as a strobe uses the old value
        step(1, 0, 4242, 0, 1, 0, 0, "R9 same cycle");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        send(1, 4343, 0, "R9 after write");
        for (int i = 0; i < 10; i++) pair(8000 + i, 0, 9000 + i, 0, "R9 unmuted");

        // R10: long zero stretch, then a single non-zero on the left
        for (int i = 0; i < SIL + 12; i++) pair(0, 0, 0, 0, "R10 zeros");
        pair(5, 0, 0, 0, "R10 break");
        for (int i = 0; i < 12; i++) pair(0, 0, 0, 0, "R10 after");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule